// File: doc/BRIEF.md
# Outbound Address Window Translator

This block turns a 64-bit local bus address into a link-side address and a transaction kind, using eight programmable windows. Each window holds a 64-bit match value, a 64-bit mask and a 64-bit remap value, each kept as two 32-bit words. A 32-bit actions word selects the kind, memory or I/O. All of these registers sit behind a word-addressed 32-bit register port with combinational readback.

A request (address plus valid) is compared against every enabled window in parallel. The lowest-numbered window that hits supplies the result. The translated address, the kind, the index of the winning window and a miss flag are all registered and appear one cycle after the request. A global enable input turns translation on or off as a whole. A bypass input lets requests flagged as PIO skip the windows entirely. Software programs a window's other words first and sets its enable bit last, so a half-written window never hits.

Top module: `obwin_translator`

## Requirements
- R1: The register word address is {window[2:0], field[2:0]}. The fields are: 0 match low, 1 match high, 2 remap low, 3 remap high, 4 mask low, 5 mask high, 6 actions. A write stores the full 32 bits and a read returns them. Field 7 reads as zero and ignores writes.
- R2: A window is enabled only while bit 0 of its match-low word is 1. A disabled window never hits, whatever its other words hold, and clearing the bit takes the window out of use.
- R3: An enabled window hits when (address AND m) equals (match AND m), where m is the window's 64-bit mask with bit 0 forced to 0.
- R4: On a hit, the output address is (remap AND m) OR (address AND NOT m).
- R5: On a hit, the kind output is bit 2 of the window's actions word: an actions value of 0x4 gives I/O (1) and 0x0 gives memory (0).
- R6: When several windows hit, the lowest-numbered one wins, and its index is output.
- R7: When no window hits, the miss flag is 1, the address passes through unchanged, and the kind and window index are both 0.
- R8: While the global enable is 0, every request behaves as a miss (pass-through).
- R9: While bypass is 1, a request flagged as PIO behaves as a miss. Requests not flagged as PIO, and all requests while bypass is 0, are translated normally.
- R10: The response valid is 1 exactly one cycle after each request valid. Without a request, the response fields hold their last values.
- R11: After reset, all window registers read zero, response valid is 0 and every response field is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 6 | Register word address {window, field} |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| xlateEn | input | 1 | Global translation enable |
| pioBypass | input | 1 | Lets PIO-flagged requests skip translation |
| reqValid | input | 1 | Request valid |
| reqIsPio | input | 1 | Request is PIO traffic |
| reqAddr | input | 64 | Local request address |
| rspValid | output | 1 | Response valid, one cycle after the request |
| rspAddr | output | 64 | Translated or passed-through address |
| rspIo | output | 1 | Kind: 1 I/O, 0 memory |
| rspWin | output | 3 | Index of the winning window |
| rspMiss | output | 1 | No window applied |

## Verification
A corrupted window word shows up in the very next response that touches that window. It appears as a wrong remapped address, a flipped kind bit, or a miss where a hit was due. It can also be seen straight away by reading the word back through the register port. A fault in the priority logic only becomes visible when overlapping windows both hit, so the tests include an overlap whose lower window must win. A slip in the enable or bypass gating turns a hit into a pass-through within one cycle, so every mode is tested against the same address.

// File: rtl/obx_pkg.sv
package obx_pkg;
  localparam int WIN_COUNT   = 8;
  localparam int ADDR_W      = 64;
  localparam int DATA_W      = 32;
  localparam int WIN_IDX_W   = $clog2(WIN_COUNT);
  localparam int FIELD_IDX_W = 3;
  localparam int REG_ADDR_W  = WIN_IDX_W + FIELD_IDX_W;
  localparam int KIND_IO_BIT = 2;

  typedef enum logic [FIELD_IDX_W-1:0] {
    F_MATCH_LO = 3'd0,
    F_MATCH_HI = 3'd1,
    F_REMAP_LO = 3'd2,
    F_REMAP_HI = 3'd3,
    F_MASK_LO  = 3'd4,
    F_MASK_HI  = 3'd5,
    F_ACTION   = 3'd6,
    F_SPARE    = 3'd7
  } field_e;

  typedef struct packed {
    logic                 regWr;
    logic [WIN_IDX_W-1:0] regWin;
    field_e               regField;
    logic [DATA_W-1:0]    regData;
    logic                 capture;
    logic                 translate;
  } strobe_t;
endpackage

// File: rtl/obx_ctrl.sv
module obx_ctrl
  import obx_pkg::*;
#(
  parameter int RAW = REG_ADDR_W
) (
  input  logic              regWrEn,
  input  logic [RAW-1:0]    regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              reqValid,
  input  logic              reqIsPio,
  input  logic              xlateEn,
  input  logic              pioBypass,
  output strobe_t           stb
);
  logic pioSkip;

  assign pioSkip = pioBypass & reqIsPio;

  always_comb begin
    stb.regWr     = regWrEn;
    stb.regWin    = regAddr[RAW-1 -: WIN_IDX_W];
    stb.regField  = field_e'(regAddr[FIELD_IDX_W-1:0]);
    stb.regData   = regWrData;
    stb.capture   = reqValid;
    stb.translate = xlateEn & ~pioSkip;
  end
endmodule

// File: rtl/obx_datapath.sv
module obx_datapath
  import obx_pkg::*;
#(
  parameter int NUM_WIN = WIN_COUNT,
  parameter int AW      = ADDR_W,
  parameter int DW      = DATA_W,
  localparam int IW     = $clog2(NUM_WIN)
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic [AW-1:0] reqAddr,
  output logic [DW-1:0] rdData,
  output logic          rspValid,
  output logic [AW-1:0] rspAddr,
  output logic          rspIo,
  output logic [IW-1:0] rspWin,
  output logic          rspMiss
);
  logic [NUM_WIN-1:0]         enVec;
  logic [NUM_WIN-1:0]         hitVec;
  logic [NUM_WIN-1:0]         ioVec;
  logic [NUM_WIN-1:0][AW-1:0] xlArr;
  logic [NUM_WIN-1:0][DW-1:0] rdArr;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [AW-1:0] matchQ, remapQ, maskQ, effMask;
    logic [DW-1:0] actQ;
    logic          selW;

    assign selW = stb.regWr && (stb.regWin == IW'(w));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        matchQ <= '0;
        remapQ <= '0;
        maskQ  <= '0;
        actQ   <= '0;
      end else if (selW) begin
        case (stb.regField)
          F_MATCH_LO: matchQ[DW-1:0]  <= stb.regData;
          F_MATCH_HI: matchQ[AW-1:DW] <= stb.regData;
          F_REMAP_LO: remapQ[DW-1:0]  <= stb.regData;
          F_REMAP_HI: remapQ[AW-1:DW] <= stb.regData;
          F_MASK_LO:  maskQ[DW-1:0]   <= stb.regData;
          F_MASK_HI:  maskQ[AW-1:DW]  <= stb.regData;
          F_ACTION:   actQ            <= stb.regData;
          default:    ;
        endcase
      end
    end

    always_comb begin
      case (stb.regField)
        F_MATCH_LO: rdArr[w] = matchQ[DW-1:0];
        F_MATCH_HI: rdArr[w] = matchQ[AW-1:DW];
        F_REMAP_LO: rdArr[w] = remapQ[DW-1:0];
        F_REMAP_HI: rdArr[w] = remapQ[AW-1:DW];
        F_MASK_LO:  rdArr[w] = maskQ[DW-1:0];
        F_MASK_HI:  rdArr[w] = maskQ[AW-1:DW];
        F_ACTION:   rdArr[w] = actQ;
        default:    rdArr[w] = '0;
      endcase
    end

    // the enable bit doubles as match bit 0, so it never takes part in compare
    assign effMask   = maskQ & ~AW'(1);
    assign enVec[w]  = matchQ[0];
    assign hitVec[w] = enVec[w] && ((reqAddr & effMask) == (matchQ & effMask));
    assign xlArr[w]  = (remapQ & effMask) | (reqAddr & ~effMask);
    assign ioVec[w]  = actQ[KIND_IO_BIT];
  end

  assign rdData = rdArr[stb.regWin];

  // lowest index wins: scan downward so lower hits overwrite higher ones
  logic [IW-1:0] selIdx;
  logic          anyHit;
  always_comb begin
    selIdx = '0;
    anyHit = 1'b0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        selIdx = IW'(i);
        anyHit = 1'b1;
      end
    end
  end

  logic useWin;
  assign useWin = stb.translate && anyHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspAddr  <= '0;
      rspIo    <= 1'b0;
      rspWin   <= '0;
      rspMiss  <= 1'b0;
    end else begin
      rspValid <= stb.capture;
      if (stb.capture) begin
        rspAddr <= useWin ? xlArr[selIdx] : reqAddr;
        rspIo   <= useWin ? ioVec[selIdx] : 1'b0;
        rspWin  <= useWin ? selIdx : '0;
        rspMiss <= ~useWin;
      end
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !stb.capture |=> $stable(rspAddr) && $stable(rspMiss) && $stable(rspWin));

  p_disabled_pass_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture && !stb.translate |=> rspMiss && (rspAddr == $past(reqAddr)) && !rspIo);

  p_lowest_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture && stb.translate && hitVec[0] |=> !rspMiss && (rspWin == '0));

  p_none_enabled_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture && (enVec == '0) |=> rspMiss);

  p_miss_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspMiss |-> (rspWin == '0) && !rspIo);
endmodule

// File: rtl/obwin_translator.sv
module obwin_translator
  import obx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  input  logic                  xlateEn,
  input  logic                  pioBypass,
  input  logic                  reqValid,
  input  logic                  reqIsPio,
  input  logic [ADDR_W-1:0]     reqAddr,
  output logic                  rspValid,
  output logic [ADDR_W-1:0]     rspAddr,
  output logic                  rspIo,
  output logic [WIN_IDX_W-1:0]  rspWin,
  output logic                  rspMiss
);
  strobe_t stb;

  obx_ctrl #(.RAW(REG_ADDR_W)) u_ctrl (
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .reqValid (reqValid),
    .reqIsPio (reqIsPio),
    .xlateEn  (xlateEn),
    .pioBypass(pioBypass),
    .stb      (stb)
  );

  obx_datapath #(.NUM_WIN(WIN_COUNT), .AW(ADDR_W), .DW(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .reqAddr (reqAddr),
    .rdData  (regRdData),
    .rspValid(rspValid),
    .rspAddr (rspAddr),
    .rspIo   (rspIo),
    .rspWin  (rspWin),
    .rspMiss (rspMiss)
  );
endmodule

// File: tb/obwin_translator_test.sv
module obwin_translator_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        xlateEn = 1'b1;
  logic        pioBypass = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqIsPio = 1'b0;
  logic [63:0] reqAddr = '0;
  logic        rspValid;
  logic [63:0] rspAddr;
  logic        rspIo;
  logic [2:0]  rspWin;
  logic        rspMiss;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  obwin_translator uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .xlateEn(xlateEn),
    .pioBypass(pioBypass), .reqValid(reqValid), .reqIsPio(reqIsPio),
    .reqAddr(reqAddr), .rspValid(rspValid), .rspAddr(rspAddr),
    .rspIo(rspIo), .rspWin(rspWin), .rspMiss(rspMiss)
  );

  typedef struct {
    logic [63:0] addr;
    logic        io;
    logic [2:0]  win;
    logic        miss;
    string       tag;
  } exp_t;

  exp_t expQ[$];

  logic [63:0] mMatch[8];
  logic [63:0] mRemap[8];
  logic [63:0] mMask[8];
  logic [31:0] mAct[8];

  task automatic checkEq(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t predict(logic [63:0] a, logic pio, string tag);
    exp_t e;
    logic [63:0] m;
    e.addr = a; e.io = 1'b0; e.win = 3'd0; e.miss = 1'b1; e.tag = tag;
    if (xlateEn && !(pioBypass && pio)) begin
      for (int w = 7; w >= 0; w--) begin
        m = mMask[w] & ~64'd1;
        if (mMatch[w][0] && ((a & m) == (mMatch[w] & m))) begin
          e.addr = (mRemap[w] & m) | (a & ~m);
          e.io   = mAct[w][2];
          e.win  = 3'(w);
          e.miss = 1'b0;
        end
      end
    end
    return e;
  endfunction

  task automatic wrReg(int win, int fld, logic [31:0] d);
    @(negedge clk);
    reqValid  = 1'b0;
    regWrEn   = 1'b1;
    regAddr   = {3'(win), 3'(fld)};
    regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    case (fld)
      0: mMatch[win][31:0]  = d;
      1: mMatch[win][63:32] = d;
      2: mRemap[win][31:0]  = d;
      3: mRemap[win][63:32] = d;
      4: mMask[win][31:0]   = d;
      5: mMask[win][63:32]  = d;
      6: mAct[win]          = d;
      default: ;
    endcase
  endtask

  task automatic rdCheck(int win, int fld, logic [31:0] exp, string tag);
    @(negedge clk);
    regAddr = {3'(win), 3'(fld)};
    #1;
    checkEq(tag, {32'd0, regRdData}, {32'd0, exp});
  endtask

  task automatic progWin(int win, logic [63:0] match, logic [63:0] mask,
                         logic [63:0] remap, logic [31:0] act);
    wrReg(win, 1, match[63:32]);
    wrReg(win, 4, mask[31:0]);
    wrReg(win, 5, mask[63:32]);
    wrReg(win, 2, remap[31:0]);
    wrReg(win, 3, remap[63:32]);
    wrReg(win, 6, act);
    wrReg(win, 0, match[31:0] | 32'd1); // enable set last
  endtask

  task automatic sendReq(logic [63:0] a, logic pio, string tag);
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = a;
    reqIsPio = pio;
    expQ.push_back(predict(a, pio, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // monitor: compare each response against the oldest expected item
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) begin
        total++; bad++;
        $display("FAIL R10 unexpected response actual=1 expected=0");
      end else begin
        exp_t e;
        e = expQ.pop_front();
        checkEq({e.tag, " addr"}, rspAddr, e.addr);
        checkEq({e.tag, " miss"}, {63'd0, rspMiss}, {63'd0, e.miss});
        checkEq({e.tag, " win"},  {61'd0, rspWin},  {61'd0, e.win});
        checkEq({e.tag, " kind"}, {63'd0, rspIo},   {63'd0, e.io});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] lastAddr;
    for (int w = 0; w < 8; w++) begin
      mMatch[w] = '0; mRemap[w] = '0; mMask[w] = '0; mAct[w] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    checkEq("R11 rspValid", {63'd0, rspValid}, 64'd0);
    checkEq("R11 rspAddr", rspAddr, 64'd0);
    checkEq("R11 rspMiss", {63'd0, rspMiss}, 64'd0);
    rdCheck(0, 0, 32'd0, "R11 match lo");
    rdCheck(7, 6, 32'd0, "R11 actions");
    rdCheck(4, 5, 32'd0, "R11 mask hi");

    // R7 no windows: pass-through miss
    sendReq(64'h0000_0010_8123_4567, 1'b0, "R7 empty");
    sendReq(64'hFFFF_0000_0000_0003, 1'b0, "R7 empty b2b");
    idle();

    // R2 half-programmed window (enable clear) never hits
    wrReg(3, 1, 32'h0000_0010);
    wrReg(3, 4, 32'hF000_0000);
    wrReg(3, 5, 32'hFFFF_FFFF);
    wrReg(3, 2, 32'h2000_0000);
    wrReg(3, 3, 32'h0000_0000);
    wrReg(3, 6, 32'h0000_0004);
    wrReg(3, 0, 32'h8000_0000);
    sendReq(64'h0000_0010_8123_4567, 1'b0, "R2 not enabled");
    idle();

    // R1 readback and spare field
    rdCheck(3, 4, 32'hF000_0000, "R1 mask lo");
    rdCheck(3, 6, 32'h0000_0004, "R1 actions");
    wrReg(3, 7, 32'hDEAD_BEEF);
    rdCheck(3, 7, 32'd0, "R1 spare field");
    rdCheck(3, 1, 32'h0000_0010, "R1 match hi");

    // R3 R4 R5 enable and translate
    wrReg(3, 0, 32'h8000_0001);
    rdCheck(3, 0, 32'h8000_0001, "R1 match lo");
    sendReq(64'h0000_0010_8123_4567, 1'b0, "R4 hit io");
    sendReq(64'h0000_0010_8000_0001, 1'b0, "R3 bit0 ignored");
    sendReq(64'h0000_0010_9000_0000, 1'b0, "R3 outside");
    idle();

    // R6 overlapping window 5, memory kind
    progWin(5, 64'h0000_0010_0000_0000, 64'hFFFF_FFF0_0000_0000,
            64'h0000_0004_0000_0000, 32'h0);
    sendReq(64'h0000_0010_8ABC_0000, 1'b0, "R6 overlap");
    sendReq(64'h0000_0010_1234_5678, 1'b0, "R5 memory kind");
    idle();

    // R8 global enable off
    xlateEn = 1'b0;
    sendReq(64'h0000_0010_8123_4567, 1'b0, "R8 disabled");
    idle();
    xlateEn = 1'b1;

    // R9 bypass for PIO
    pioBypass = 1'b1;
    sendReq(64'h0000_0010_8123_4567, 1'b1, "R9 pio bypass");
    sendReq(64'h0000_0010_8123_4567, 1'b0, "R9 non-pio");
    idle();
    pioBypass = 1'b0;
    sendReq(64'h0000_0010_8123_4567, 1'b1, "R9 pio no bypass");
    idle();

    // R2 disable window 3, window 5 takes over
    wrReg(3, 0, 32'h8000_0000);
    sendReq(64'h0000_0010_8123_4567, 1'b0, "R2 disabled again");

    // R10 hold after last response
    lastAddr = predict(64'h0000_0010_8123_4567, 1'b0, "").addr;
    idle();
    @(negedge clk);
    @(negedge clk);
    checkEq("R10 valid low", {63'd0, rspValid}, 64'd0);
    checkEq("R10 addr held", rspAddr, lastAddr);
    checkEq("R10 queue drained", 64'(expQ.size()), 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule